// File: doc/BRIEF.md
# Serial Receiver with Byte Holding Stage

This block is the receive half of an asynchronous serial port. A strobe at sixteen times the bit rate paces all receive timing. The line is first passed through a short synchronizer. A falling edge on the idle-high line starts a sub-bit counter, and that counter checks the line again at the middle of the start bit. A glitch that has gone back high by then is dropped as a false start. Data bits arrive least significant first and are shifted in at their centres. The optional parity bit and the stop bit are then sampled in the same way.

A finished character moves into a one-byte holding register, and its parity, framing and break flags travel with it. The status outputs always describe the byte currently held. A host read strobe empties the holding register and clears those flags in the same step. A data-ready interrupt is produced from the ready flag and an enable input. Baud generation, queueing beyond one byte and the transmit side are handled elsewhere.

Top module: `uart_rx_hold`

## Requirements
- R1: After synchronous reset, `status` is 0, `irq` is 0 and `rd_data` is 0.
- R2: A low pulse on `rxd` that is back high before the mid-start-bit check (8 ticks after the edge) produces no character, and `status[0]` stays 0.
- R3: With 8 data bits and no parity, each byte sent least significant bit first at 16 ticks per bit appears on `rd_data` with `status[0]` = 1.
- R4: `word_len` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. The received bits are right-aligned in `rd_data`, and the unused upper bits read 0.
- R5: When `parity_en` = 1, one parity bit follows the data. `parity_odd` = 1 selects odd parity and 0 selects even parity. A mismatch sets `status[2]`, and a correct parity bit leaves it 0.
- R6: A stop bit sampled as 0 sets `status[3]` (framing error) for that byte.
- R7: When the data bits, the parity bit (if enabled) and the stop bit are all 0, `status[4]` (break) is set together with `status[3]`.
- R8: `status[0]` (data ready) goes to 1 when a character completes. A `rd_stb` pulse with no character completing in the same cycle clears `status[4:0]` on the next cycle.
- R9: If a character completes while `status[0]` is already 1 and no read is made, the new character is discarded. `status[1]` (overrun) is set, while `rd_data` and the held flags keep their values until the next read clears them.
- R10: `irq` is a registered copy of `status[0]` AND `irq_en`. It stays 0 while `irq_en` is 0 and drops when the byte is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| word_len | input | 2 | Data bits: code + 5 |
| parity_en | input | 1 | 1 = a parity bit follows the data |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| irq_en | input | 1 | Data-ready interrupt enable |
| rd_stb | input | 1 | One-cycle read strobe for the holding register |
| rd_data | output | 8 | Held received byte |
| status | output | 5 | [0] ready, [1] overrun, [2] parity, [3] framing, [4] break |
| irq | output | 1 | Data-ready interrupt |

## Verification
If the sub-bit counter or the bit index drifts, the fault shows on `rd_data` or on the flags of the very next character: a bit is shifted to the wrong place or the stop bit is sampled in the wrong slot. If the false-start check or the arming logic is wrong, a spurious ready appears within about one bit time of a short low glitch. If the holding stage mishandles a read or an overrun, `status` is wrong one cycle after the strobe or after the second character completes, so each such fault is visible within a character time.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int RX_DATA_W = 8;
  localparam int RX_MIN_LEN = 5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rx_state_e;

  typedef struct packed {
    logic [RX_DATA_W-1:0] data;
    logic                 perr;
    logic                 ferr;
    logic                 brk;
  } rx_word_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rx,
  input  logic [1:0] word_len,
  input  logic       parity_en,
  input  logic       parity_odd,
  output logic       done,
  output rx_word_t   word
);
  localparam int CW = $clog2(OSR);
  localparam int NW = $clog2(RX_DATA_W + 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e            state;
  logic [CW-1:0]        cnt;
  logic [NW-1:0]        bit_idx;
  logic [RX_DATA_W-1:0] shreg;
  logic                 par_bit;
  logic                 armed;
  logic [NW-1:0]        nbits;
  logic [RX_DATA_W-1:0] aligned;
  logic                 slot_end;

  assign nbits    = NW'(RX_MIN_LEN) + NW'(word_len);
  assign aligned  = shreg >> (NW'(RX_DATA_W) - nbits);
  assign slot_end = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      armed   <= 1'b0;
      done    <= 1'b0;
      word    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (tick) begin
            if (armed && !rx) begin
              state <= S_START;
              cnt   <= '0;
              armed <= 1'b0;
            end else if (rx) begin
              armed <= 1'b1;
            end
          end
        end
        S_START: begin
          if (tick) begin
            if (cnt == MID) begin
              cnt <= '0;
              if (!rx) begin
                state   <= S_DATA;
                bit_idx <= '0;
                par_bit <= 1'b0;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (slot_end) begin
            cnt   <= '0;
            shreg <= {rx, shreg[RX_DATA_W-1:1]};
            if (bit_idx == nbits - 1'b1) state <= parity_en ? S_PAR : S_STOP;
            else                         bit_idx <= bit_idx + 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAR: begin
          if (slot_end) begin
            cnt     <= '0;
            par_bit <= rx;
            state   <= S_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (slot_end) begin
            cnt        <= '0;
            state      <= S_IDLE;
            done       <= 1'b1;
            word.data  <= aligned;
            word.perr  <= parity_en & (^aligned ^ par_bit ^ parity_odd);
            word.ferr  <= !rx;
            word.brk   <= !rx && (aligned == '0) && !par_bit;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_holding.sv
module uart_rx_holding
  import uart_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  rx_word_t             word,
  input  logic                 rd_stb,
  input  logic                 irq_en,
  output logic [RX_DATA_W-1:0] rd_data,
  output logic [4:0]           status,
  output logic                 irq
);
  logic       ready_n, ovr_n, take;
  logic [2:0] tags_n;

  always_comb begin
    ready_n = status[0];
    ovr_n   = status[1];
    tags_n  = status[4:2];
    take    = 1'b0;
    if (load) begin
      if (!status[0] || rd_stb) begin
        take    = 1'b1;
        ready_n = 1'b1;
        ovr_n   = 1'b0;
        tags_n  = {word.brk, word.ferr, word.perr};
      end else begin
        ovr_n = 1'b1;
      end
    end else if (rd_stb) begin
      ready_n = 1'b0;
      ovr_n   = 1'b0;
      tags_n  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      status  <= '0;
      irq     <= 1'b0;
    end else begin
      if (take) rd_data <= word.data;
      status <= {tags_n, ovr_n, ready_n};
      irq    <= ready_n & irq_en;
    end
  end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick16,
  input  logic                 rxd,
  input  logic [1:0]           word_len,
  input  logic                 parity_en,
  input  logic                 parity_odd,
  input  logic                 irq_en,
  input  logic                 rd_stb,
  output logic [RX_DATA_W-1:0] rd_data,
  output logic [4:0]           status,
  output logic                 irq
);
  logic     rx_s;
  logic     frame_done;
  rx_word_t frame_word;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(rx_s)
  );

  uart_rx_core #(.OSR(OSR)) u_core (
    .clk(clk), .rst(rst), .tick(tick16), .rx(rx_s),
    .word_len(word_len), .parity_en(parity_en), .parity_odd(parity_odd),
    .done(frame_done), .word(frame_word)
  );

  uart_rx_holding u_hold (
    .clk(clk), .rst(rst), .load(frame_done), .word(frame_word),
    .rd_stb(rd_stb), .irq_en(irq_en),
    .rd_data(rd_data), .status(status), .irq(irq)
  );
endmodule

// File: rtl/uart_rx_hold_chk.sv
module uart_rx_hold_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_stb,
  input logic       irq_en,
  input logic       frame_done,
  input logic [7:0] rd_data,
  input logic [4:0] status,
  input logic       irq
);
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rd_stb && !frame_done |=> status == 5'd0);                         // R8
  AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> status[0]);                                         // R8
  AST_FLAGS_NEED_READY: assert property (@(posedge clk) disable iff (rst)
    (|status[4:1]) |-> status[0]);                                     // R8
  AST_BREAK_FRAMING: assert property (@(posedge clk) disable iff (rst)
    status[4] |-> status[3]);                                          // R7
  AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    status[0] && frame_done && !rd_stb |=> status[1] && $stable(rd_data)); // R9
  AST_IRQ_READY: assert property (@(posedge clk) disable iff (rst)
    irq |-> status[0]);                                                // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);                                                 // R10
endmodule

bind uart_rx_hold uart_rx_hold_chk u_chk (
  .clk(clk), .rst(rst), .rd_stb(rd_stb), .irq_en(irq_en),
  .frame_done(frame_done), .rd_data(rd_data), .status(status), .irq(irq)
);

// File: tb/uart_rx_hold_tb.sv
module uart_rx_hold_tb;
  localparam int BIT_CLK = 64;

  typedef struct {
    logic [7:0] data;
    logic       pe, fe, bi;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] word_len = 2'd3;
  logic       parity_en = 1'b0, parity_odd = 1'b0, irq_en = 1'b1, rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] status;
  logic       irq;
  logic [1:0] tdiv;
  logic       tick16;

  int   checks = 0, errors = 0, cycles = 0;
  bit   mon_en = 1'b1;
  exp_t sb[$];

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) tdiv <= 2'd0;
    else     tdiv <= tdiv + 2'd1;
    cycles <= cycles + 1;
  end
  assign tick16 = (tdiv == 2'd3);

  uart_rx_hold u_dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .word_len(word_len),
    .parity_en(parity_en), .parity_odd(parity_odd), .irq_en(irq_en),
    .rd_stb(rd_stb), .rd_data(rd_data), .status(status), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic line(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  // driver: pushes the expected item, then shifts the frame out LSB first
  task automatic send(input logic [7:0] d, input bit push, input bit flip, input logic stop_v);
    int   n = 5 + int'(word_len);
    logic [7:0] dm = d & 8'((1 << n) - 1);
    logic pbit = (^dm) ^ parity_odd ^ flip;
    exp_t e;
    e.data = dm;
    e.pe   = parity_en & flip;
    e.fe   = !stop_v;
    e.bi   = !stop_v && (dm == 8'd0) && !(parity_en && pbit);
    if (push) sb.push_back(e);
    line(1'b0, BIT_CLK);
    for (int i = 0; i < n; i++) line(dm[i], BIT_CLK);
    if (parity_en) line(pbit, BIT_CLK);
    line(stop_v, BIT_CLK);
    line(1'b1, 2 * BIT_CLK);
  endtask

  task automatic read_pulse();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pops expected items as the holding register fills
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && !rst && status[0]) begin
        exp_t e;
        if (sb.size() == 0) begin
          check(1'b0, "R8 unexpected byte", rd_data, 0);
        end else begin
          e = sb.pop_front();
          check(rd_data == e.data, "R3/R4 data", rd_data, e.data);
          check(status[2] == e.pe, "R5 parity flag", status[2], e.pe);
          check(status[3] == e.fe, "R6 framing flag", status[3], e.fe);
          check(status[4] == e.bi, "R7 break flag", status[4], e.bi);
        end
        check(irq == irq_en, "R10 irq level", irq, irq_en);
        read_pulse();
        check(status == 5'd0, "R8 cleared after read", status, 0);
        check(irq == 1'b0, "R10 irq dropped after read", irq, 0);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    check(1'b0, "watchdog", cycles, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(status == 5'd0, "R1 status after reset", status, 0);
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
    check(rd_data == 8'd0, "R1 data after reset", rd_data, 0);
    rst = 1'b0;
    line(1'b1, 2 * BIT_CLK);

    // R3: 8N1 patterns
    send(8'hA5, 1, 0, 1'b1);
    send(8'h01, 1, 0, 1'b1);
    send(8'hFE, 1, 0, 1'b1);

    // R4: shorter words
    word_len = 2'd0; send(8'hFF, 1, 0, 1'b1);
    word_len = 2'd1; send(8'h2A, 1, 0, 1'b1);
    word_len = 2'd2; send(8'hC7, 1, 0, 1'b1);
    word_len = 2'd3;

    // R5: parity good and bad, even and odd
    parity_en = 1'b1; parity_odd = 1'b0;
    send(8'h37, 1, 0, 1'b1);
    send(8'h37, 1, 1, 1'b1);
    parity_odd = 1'b1;
    send(8'h80, 1, 0, 1'b1);
    send(8'h80, 1, 1, 1'b1);

    // R6: framing only; R7: break with even parity
    parity_odd = 1'b0;
    send(8'h55, 1, 0, 1'b0);
    send(8'h00, 1, 0, 1'b0);
    parity_en = 1'b0;

    // R10: interrupt masked
    irq_en = 1'b0;
    send(8'h5A, 1, 0, 1'b1);
    irq_en = 1'b1;

    // R2: false start shorter than half a bit
    line(1'b0, 12);
    line(1'b1, 4 * BIT_CLK);
    check(status[0] == 1'b0, "R2 false start ignored", status[0], 0);
    send(8'h3C, 1, 0, 1'b1);

    // R9: overrun, monitor paused
    repeat (4) @(negedge clk);
    mon_en = 1'b0;
    send(8'h96, 0, 0, 1'b1);
    send(8'h69, 0, 0, 1'b1);
    check(status[1:0] == 2'b11, "R9 overrun set", status, 3);
    check(rd_data == 8'h96, "R9 first byte kept", rd_data, 8'h96);
    check(status[4:2] == 3'd0, "R9 held flags kept", status[4:2], 0);
    read_pulse();
    check(status == 5'd0, "R9 overrun cleared by read", status, 0);
    mon_en = 1'b1;

    repeat (20) @(negedge clk);
    check(sb.size() == 0, "R8 all bytes delivered", sb.size(), 0);
    finish_run();
  end
endmodule